// File: doc/BRIEF.md
# Quad dual-mode set/reset latch

This block holds four independent storage bits. Each bit has its own data input and its own active-low set input. All bits share one active-low gate and one active-low clear. While the gate is low, each bit does one of two things. It acts as a transparent data latch when its set input is held low. It acts as a clear-dominant set/reset latch when the set input is driven as a control. While the gate is high, every bit keeps its value. The clear input overrides everything else and forces all bits to zero.

The per-bit rule is: a low data input clears the bit, a low set input with high data sets it, and both high leaves it alone. Transparent use is a special case of this rule, because with the set input low the output simply equals the data input. A parameter chooses the implementation. The default is a registered model that applies the rule on each rising system clock edge, which suits an FPGA fabric. The other choice is a true level-sensitive latch.

Top module: `dml_quad`

## Requirements
- R1: While `rst` is high at a rising clock edge, all bits of `q` are 0 after that edge.
- R2: With `rst` low, `clr_n` low at an edge forces every bit of `q` to 0, whatever `gate_n`, `din` and `set_n` are.
- R3: With `rst` low, `clr_n` high and `gate_n` high at an edge, `q` keeps its previous value for every bit.
- R4: With `gate_n` low and a bit's `set_n` low, that bit of `q` takes the value of its `din` bit.
- R5: With `gate_n` low, a bit whose `din` is 0 becomes 0, including when its `set_n` is also 0 (clear dominates set).
- R6: With `gate_n` low, a bit whose `din` is 1 and `set_n` is 0 becomes 1.
- R7: With `gate_n` low, a bit whose `din` and `set_n` are both 1 keeps its previous value.
- R8: The bits are independent. Each bit follows R4 to R7 using only its own `din` and `set_n` bits, and bit i of every vector belongs to lane i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (used by the registered model) |
| rst | input | 1 | Synchronous active-high system reset |
| clr_n | input | 1 | Active-low clear of all bits, highest functional priority |
| gate_n | input | 1 | Active-low shared gate; high means hold |
| din | input | WIDTH | Per-bit data input; low clears the bit when gated |
| set_n | input | WIDTH | Per-bit active-low set, effective only when data is high |
| q | output | WIDTH | Stored bits |

## Verification
Directed patterns come first. The transparent pattern holds `set_n` at all zeros and walks `din`, which shows a transparent latch apart from one that only sets. Driving `din` and `set_n` low together shows whether clear or set dominates. Driving both high on bits that already hold opposite values shows a true hold apart from an accidental clear or set. Gate-high and clear-low intervals are then applied with hostile data on the inputs. An exhaustive sweep follows: every gate, clear, data and set combination is applied from several starting patterns, with the lanes given different values, so that crossed or shared lanes are exposed.

// File: rtl/dml_pkg.sv
package dml_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_ZERO = 2'd1,
    ACT_ONE  = 2'd2
  } act_e;
endpackage

// File: rtl/dml_decode.sv
// Per-bit action decode: clear priority, gate, then clear-dominant set/reset.
module dml_decode
  import dml_pkg::*;
(
  input  logic clr_n,
  input  logic gate_n,
  input  logic din,
  input  logic set_n,
  output act_e act
);
  always_comb begin
    if (!clr_n)       act = ACT_ZERO;
    else if (gate_n)  act = ACT_HOLD;
    else if (!din)    act = ACT_ZERO;
    else if (!set_n)  act = ACT_ONE;
    else              act = ACT_HOLD;
  end
endmodule

// File: rtl/dml_cell.sv
// One storage bit; LATCH_MODE picks a level-sensitive latch or a flop model.
module dml_cell
  import dml_pkg::*;
#(
  parameter bit LATCH_MODE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  act_e act,
  output logic q
);
  generate
    if (LATCH_MODE) begin : g_latch
      always_latch begin
        if (rst)                 q = 1'b0;
        else if (act == ACT_ZERO) q = 1'b0;
        else if (act == ACT_ONE)  q = 1'b1;
      end
    end else begin : g_flop
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= 1'b0;
        end else begin
          case (act)
            ACT_ZERO: q <= 1'b0;
            ACT_ONE:  q <= 1'b1;
            default:  q <= q;
          endcase
        end
      end
    end
  endgenerate
endmodule

// File: rtl/dml_quad.sv
// Quad dual-mode latch: shared gate and clear, per-bit data and set.
module dml_quad
  import dml_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter bit LATCH_MODE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n,
  input  logic             gate_n,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] set_n,
  output logic [WIDTH-1:0] q
);
  act_e act [WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    dml_decode u_dec (
      .clr_n  (clr_n),
      .gate_n (gate_n),
      .din    (din[i]),
      .set_n  (set_n[i]),
      .act    (act[i])
    );
    dml_cell #(.LATCH_MODE(LATCH_MODE)) u_cell (
      .clk (clk),
      .rst (rst),
      .act (act[i]),
      .q   (q[i])
    );
  end
endmodule

// File: rtl/dml_quad_chk.sv
// Checker for the registered model, attached to dml_quad by bind.
module dml_quad_chk #(
  parameter int WIDTH      = 4,
  parameter bit LATCH_MODE = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_n,
  input logic             gate_n,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] set_n,
  input logic [WIDTH-1:0] q
);
  if (!LATCH_MODE) begin : g_reg_checks
    p_clear_all_r2: assert property (@(posedge clk) disable iff (rst)
      (!rst && !clr_n) |=> (q == '0));

    p_gate_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (!rst && clr_n && gate_n) |=> $stable(q));

    p_zero_wins_r5: assert property (@(posedge clk) disable iff (rst)
      (!rst && clr_n && !gate_n) |=> ((q & ~$past(din)) == '0));

    p_set_one_r6: assert property (@(posedge clk) disable iff (rst)
      (!rst && clr_n && !gate_n) |=> ((~q & $past(din) & ~$past(set_n)) == '0));

    p_both_high_keep_r7: assert property (@(posedge clk) disable iff (rst)
      (!rst && clr_n && !gate_n) |=> (((q ^ $past(q)) & $past(din & set_n)) == '0));
  end
endmodule

bind dml_quad dml_quad_chk #(.WIDTH(WIDTH), .LATCH_MODE(LATCH_MODE)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .clr_n  (clr_n),
  .gate_n (gate_n),
  .din    (din),
  .set_n  (set_n),
  .q      (q)
);

// File: tb/dml_quad_tb.sv
`timescale 1ns/1ps
module dml_quad_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         clr_n = 1'b1;
  logic         gate_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] set_n = '1;
  logic [W-1:0] q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] exp_q [$];
  string        exp_tag [$];
  logic [W-1:0] model = '0;

  always #2 clk = ~clk;

  dml_quad #(.WIDTH(W), .LATCH_MODE(1'b0)) u_dut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .gate_n(gate_n),
    .din(din), .set_n(set_n), .q(q)
  );

  // Reference truth table per bit, written from the requirements.
  function automatic logic [W-1:0] ref_step(logic [W-1:0] cur, logic r, logic c_n,
                                            logic g_n, logic [W-1:0] d, logic [W-1:0] s_n);
    logic [W-1:0] nxt;
    if (r || !c_n) return '0;
    if (g_n) return cur;
    for (int b = 0; b < W; b++) begin
      case ({d[b], s_n[b]})
        2'b00, 2'b01: nxt[b] = 1'b0;
        2'b10:        nxt[b] = 1'b1;
        default:      nxt[b] = cur[b];
      endcase
    end
    return nxt;
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected output.
  task automatic step(logic r, logic c_n, logic g_n, logic [W-1:0] d,
                      logic [W-1:0] s_n, string tag);
    @(negedge clk);
    rst = r; clr_n = c_n; gate_n = g_n; din = d; set_n = s_n;
    model = ref_step(model, r, c_n, g_n, d, s_n);
    exp_q.push_back(model);
    exp_tag.push_back(tag);
  endtask

  // Monitor: compares after each edge that the driver prepared for.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = exp_tag.pop_front();
      checks++;
      if (q !== e) begin
        errors++;
        $display("FAIL %s: q=%b expected %b", t, q, e);
      end
    end
  end

  initial begin
    // R1 reset state, with hostile inputs around it
    step(1, 1, 0, 4'b1111, 4'b0000, "R1");
    step(1, 0, 0, 4'b1010, 4'b0000, "R1");
    step(1, 1, 1, 4'b1111, 4'b1111, "R1");
    // R4 transparent use: set_n held low, din walks
    step(0, 1, 0, 4'b1010, 4'b0000, "R4");
    step(0, 1, 0, 4'b0101, 4'b0000, "R4");
    step(0, 1, 0, 4'b1111, 4'b0000, "R4");
    step(0, 1, 0, 4'b0000, 4'b0000, "R4");
    // R6 set, then R7 keep, then R5 clear-dominant
    step(0, 1, 0, 4'b1111, 4'b0110, "R6");
    step(0, 1, 0, 4'b1111, 4'b1111, "R7");
    step(0, 1, 0, 4'b0011, 4'b0000, "R5");
    step(0, 1, 0, 4'b1111, 4'b1111, "R7");
    // R3 hold with gate high while inputs would change things
    step(0, 1, 1, 4'b0000, 4'b0000, "R3");
    step(0, 1, 1, 4'b1111, 4'b0000, "R3");
    step(0, 1, 1, 4'b0101, 4'b1010, "R3");
    // R2 clear overrides gate and set
    step(0, 1, 0, 4'b1111, 4'b0000, "R4");
    step(0, 0, 0, 4'b1111, 4'b0000, "R2");
    step(0, 0, 1, 4'b1111, 4'b0000, "R2");
    step(0, 1, 0, 4'b1111, 4'b1111, "R7");
    // R8 exhaustive sweep from several starting patterns, lanes differ
    for (int p = 0; p < 4; p++) begin
      for (int cg = 0; cg < 4; cg++) begin
        for (int ds = 0; ds < 256; ds++) begin
          logic [W-1:0] start;
          start = (p == 0) ? 4'b0000 : (p == 1) ? 4'b1111 : (p == 2) ? 4'b1010 : 4'b0110;
          step(0, 1, 0, start, 4'b0000, "R4");
          step(0, cg[1], cg[0], ds[7:4], ds[3:0], "R8");
        end
      end
    end
    step(1, 1, 0, 4'b1111, 4'b0000, "R1");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("watchdog expired before the sequence completed");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule